// File: doc/BRIEF.md
# Dual-Threshold Overcurrent Circuit Breaker

This block is the latching trip controller of a hot-swap power path. It watches two digital comparator outputs that report the drop across the sense resistor: one above a low threshold and one above a high threshold. Each comparator feeds its own qualification counter. A path trips only when its comparator has stayed asserted for an unbroken run of clock cycles, and that run length is set by a parameter. The high-threshold path has a short run length so that it catches hard shorts. The low-threshold path has a long run length so that it catches sustained overload. A power-up sequencer arms each path on its own. The high-threshold path is armed when the load starts to charge. The low-threshold path is armed later, once the soft-start current limit has let go.

Three other sources can request a trip directly: overvoltage, an external fault, and power-good failure. All five sources feed one shared latch. When any request is present, the gate-enable output drops in the same cycle. From the next clock edge the latch holds, the active-low fault flag is driven low, and a cause register keeps the source of the first trip. The sequencer's general logic reset clears only the qualification counters. The latch can be released only by a separate clear input, which comes from a reset qualifier that looks for a longer hold time.

Top module: `ocb_breaker`

## Requirements
- R1: After the synchronous reset `rst`, the latch is open: `tripped`=0, `fault_n`=1, `trip_cause`=0, and `gate_en` follows `gate_req`.
- R2: With `slow_arm`=1, the low-threshold path trips at the clock edge that samples `cmp_slow` high for the SLOW_QUAL-th consecutive time. A run of SLOW_QUAL-1 high samples does not trip.
- R3: With `fast_arm`=1, the high-threshold path trips at the clock edge that samples `cmp_fast` high for the FAST_QUAL-th consecutive time. A run of FAST_QUAL-1 high samples does not trip.
- R4: If a comparator input is sampled low, its run restarts. The next trip on that path needs a full new run.
- R5: While a path's arm input is low, that path cannot trip and its count is held at zero. After arming, the path needs a full run of high samples taken while armed.
- R6: `ovp_req`, `ext_req` and `pg_fail_req` each set the latch at the next clock edge.
- R7: `gate_en` is low in any cycle in which a trip request is present (a qualified path or a direct request), and in every cycle while the latch is set. Otherwise `gate_en` equals `gate_req`.
- R8: `fault_n` is 0 exactly while `tripped` is 1.
- R9: `trip_cause` records the source of the trip that set the latch, using 1=fast, 2=slow, 3=overvoltage, 4=external, 5=power-good. When requests coincide, they rank in that same order (fast highest). Later requests do not change the cause while the latch is set.
- R10: `brk_clear` opens the latch and returns `trip_cause` to 0 at the next edge. If a trip request is present in the same cycle, the trip wins.
- R11: `seq_rst` restarts both qualification runs and blocks qualification in that cycle, but leaves the latch and the cause unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| seq_rst | input | 1 | General logic reset from the sequencer; restarts the runs only |
| fast_arm | input | 1 | Enables the high-threshold path |
| slow_arm | input | 1 | Enables the low-threshold path |
| cmp_fast | input | 1 | Sense drop above the high threshold |
| cmp_slow | input | 1 | Sense drop above the low threshold |
| ovp_req | input | 1 | Overvoltage trip request |
| ext_req | input | 1 | External fault trip request |
| pg_fail_req | input | 1 | Power-good failure trip request |
| brk_clear | input | 1 | Latch release from the reset qualifier |
| gate_req | input | 1 | Gate-enable request from the sequencer |
| gate_en | output | 1 | Gate-enable to the driver |
| fault_n | output | 1 | Active-low latched fault flag |
| tripped | output | 1 | Latch state |
| trip_cause | output | 3 | Source of the first trip |

## Verification
`gate_en` is combinational, so the bench checks it 1 ns after it drives new inputs, inside the same cycle. `tripped`, `fault_n` and `trip_cause` change one edge after the request, because a path qualifies in the cycle of its last required high sample and the latch is the only register after that. The bench therefore checks them at the following falling edge. A bench-side model advances its own run counters at each rising edge, and every expected value is taken from that model at those two sample points.

// File: rtl/ocb_pkg.sv
package ocb_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_FAST  = 3'd1,
        CAUSE_SLOW  = 3'd2,
        CAUSE_OVP   = 3'd3,
        CAUSE_EXT   = 3'd4,
        CAUSE_PGOOD = 3'd5
    } trip_cause_e;

    typedef struct packed {
        logic fast;
        logic slow;
        logic ovp;
        logic ext;
        logic pgood;
    } trip_req_t;

    function automatic logic req_any(input trip_req_t r);
        return r.fast | r.slow | r.ovp | r.ext | r.pgood;
    endfunction

    // Fixed ranking: fast over slow over overvoltage over external over power-good.
    function automatic trip_cause_e req_rank(input trip_req_t r);
        trip_cause_e c;
        c = CAUSE_NONE;
        if (r.pgood) c = CAUSE_PGOOD;
        if (r.ext)   c = CAUSE_EXT;
        if (r.ovp)   c = CAUSE_OVP;
        if (r.slow)  c = CAUSE_SLOW;
        if (r.fast)  c = CAUSE_FAST;
        return c;
    endfunction

endpackage

// File: rtl/ocb_qual_timer.sv
module ocb_qual_timer #(
    parameter int QUAL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic arm,
    input  logic cmp,
    output logic qualified
);
    localparam int CW = (QUAL < 2) ? 1 : $clog2(QUAL);
    localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

    logic [CW-1:0] run_cnt;
    logic          run_live;

    assign run_live  = arm & cmp & ~restart;
    assign qualified = run_live & (run_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (!run_live) begin
            run_cnt <= '0;
        end else if (run_cnt != LAST) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    a_r2_run_bounded: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= LAST);
    a_r4_restart_on_low: assert property (@(posedge clk) disable iff (rst)
        !cmp |=> run_cnt == '0);
    a_r5_disarmed_silent: assert property (@(posedge clk) disable iff (rst)
        !arm |-> !qualified);
    a_r11_restart_blocks: assert property (@(posedge clk) disable iff (rst)
        restart |-> !qualified);

endmodule

// File: rtl/ocb_trip_latch.sv
module ocb_trip_latch
    import ocb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  trip_req_t   req,
    input  logic        clear,
    output logic        latched,
    output trip_cause_e cause
);
    logic        hit;
    trip_cause_e ranked;

    always_comb begin
        hit    = req_any(req);
        ranked = req_rank(req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latched <= 1'b0;
            cause   <= CAUSE_NONE;
        end else if (hit) begin
            latched <= 1'b1;
            if (!latched) cause <= ranked;
        end else if (clear) begin
            latched <= 1'b0;
            cause   <= CAUSE_NONE;
        end
    end

    a_r6_request_sets: assert property (@(posedge clk) disable iff (rst)
        hit |=> latched);
    a_r10_trip_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (hit && clear) |=> latched);
    a_r9_cause_held: assert property (@(posedge clk) disable iff (rst)
        (latched && $past(latched)) |-> $stable(cause));
    a_r9_cause_valid: assert property (@(posedge clk) disable iff (rst)
        latched |-> cause != CAUSE_NONE);
    a_r10_clear_opens: assert property (@(posedge clk) disable iff (rst)
        (clear && !hit) |=> !latched);

endmodule

// File: rtl/ocb_breaker.sv
module ocb_breaker
    import ocb_pkg::*;
#(
    parameter int SLOW_QUAL = 2250,
    parameter int FAST_QUAL = 63
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       seq_rst,
    input  logic       fast_arm,
    input  logic       slow_arm,
    input  logic       cmp_fast,
    input  logic       cmp_slow,
    input  logic       ovp_req,
    input  logic       ext_req,
    input  logic       pg_fail_req,
    input  logic       brk_clear,
    input  logic       gate_req,
    output logic       gate_en,
    output logic       fault_n,
    output logic       tripped,
    output logic [2:0] trip_cause
);
    localparam int NPATH = 2;
    localparam int QUALS [NPATH] = '{FAST_QUAL, SLOW_QUAL};

    logic [NPATH-1:0] path_arm;
    logic [NPATH-1:0] path_cmp;
    logic [NPATH-1:0] path_q;
    trip_req_t        req;
    trip_cause_e      cause;
    logic             latched;

    assign path_arm = {slow_arm, fast_arm};
    assign path_cmp = {cmp_slow, cmp_fast};

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        ocb_qual_timer #(.QUAL(QUALS[p])) i_qual (
            .clk      (clk),
            .rst      (rst),
            .restart  (seq_rst),
            .arm      (path_arm[p]),
            .cmp      (path_cmp[p]),
            .qualified(path_q[p])
        );
    end

    always_comb begin
        req.fast  = path_q[0];
        req.slow  = path_q[1];
        req.ovp   = ovp_req;
        req.ext   = ext_req;
        req.pgood = pg_fail_req;
    end

    ocb_trip_latch i_latch (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .clear  (brk_clear),
        .latched(latched),
        .cause  (cause)
    );

    assign gate_en    = gate_req & ~latched & ~req_any(req);
    assign fault_n    = ~latched;
    assign tripped    = latched;
    assign trip_cause = cause;

    a_r7_gate_off_latched: assert property (@(posedge clk) disable iff (rst)
        tripped |-> !gate_en);
    a_r7_gate_off_request: assert property (@(posedge clk) disable iff (rst)
        (ovp_req || ext_req || pg_fail_req) |-> !gate_en);
    a_r8_flag_after_request: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n) |-> $past(ovp_req || ext_req || pg_fail_req || path_q != '0));

endmodule

// File: tb/test_ocb_breaker.sv
module test_ocb_breaker;
    localparam int SQ = 12;
    localparam int FQ = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic seq_rst = 0, fast_arm = 0, slow_arm = 0, cmp_fast = 0, cmp_slow = 0;
    logic ovp_req = 0, ext_req = 0, pg_fail_req = 0, brk_clear = 0, gate_req = 0;
    logic gate_en, fault_n, tripped;
    logic [2:0] trip_cause;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    int m_cs = 0, m_cf = 0;
    bit m_lat = 0;
    int m_cause = 0;

    always #4 clk = ~clk;

    ocb_breaker #(.SLOW_QUAL(SQ), .FAST_QUAL(FQ)) i_ocb_breaker (
        .clk(clk), .rst(rst), .seq_rst(seq_rst), .fast_arm(fast_arm),
        .slow_arm(slow_arm), .cmp_fast(cmp_fast), .cmp_slow(cmp_slow),
        .ovp_req(ovp_req), .ext_req(ext_req), .pg_fail_req(pg_fail_req),
        .brk_clear(brk_clear), .gate_req(gate_req), .gate_en(gate_en),
        .fault_n(fault_n), .tripped(tripped), .trip_cause(trip_cause)
    );

    function automatic bit q_fast();
        return fast_arm && cmp_fast && !seq_rst && (m_cf == FQ - 1);
    endfunction
    function automatic bit q_slow();
        return slow_arm && cmp_slow && !seq_rst && (m_cs == SQ - 1);
    endfunction
    function automatic int want_cause();
        if (q_fast()) return 1;
        if (q_slow()) return 2;
        if (ovp_req) return 3;
        if (ext_req) return 4;
        if (pg_fail_req) return 5;
        return 0;
    endfunction
    function automatic bit want_gate();
        return gate_req && !m_lat && (want_cause() == 0);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        int wc;
        wc = want_cause();
        if (wc != 0) begin
            if (!m_lat) m_cause = wc;
            m_lat = 1;
        end else if (brk_clear) begin
            m_lat = 0;
            m_cause = 0;
        end
        m_cf = (fast_arm && cmp_fast && !seq_rst) ? ((m_cf == FQ - 1) ? m_cf : m_cf + 1) : 0;
        m_cs = (slow_arm && cmp_slow && !seq_rst) ? ((m_cs == SQ - 1) ? m_cs : m_cs + 1) : 0;
    endtask

    // Inputs have been set after a falling edge; check, clock, check again.
    task automatic step(input string tag);
        #1;
        chk({tag, " gate_en R7"}, int'(gate_en), int'(want_gate()));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({tag, " tripped"}, int'(tripped), int'(m_lat));
        chk({tag, " fault_n R8"}, int'(fault_n), int'(!m_lat));
        chk({tag, " cause R9"}, int'(trip_cause), m_cause);
    endtask

    task automatic idle();
        seq_rst = 0; cmp_fast = 0; cmp_slow = 0; ovp_req = 0;
        ext_req = 0; pg_fail_req = 0; brk_clear = 0;
    endtask

    task automatic do_clear(input string tag);
        idle(); brk_clear = 1; step(tag); brk_clear = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        gate_req = 1;
        #1;
        chk("R1 tripped", int'(tripped), 0);
        chk("R1 fault_n", int'(fault_n), 1);
        chk("R1 cause", int'(trip_cause), 0);
        chk("R1 gate_en", int'(gate_en), 1);

        // R2: one short of the run, then a full run
        slow_arm = 1; fast_arm = 1;
        cmp_slow = 1;
        for (int i = 0; i < SQ - 1; i++) step("R2 short");
        chk("R2 no trip short run", int'(tripped), 0);
        cmp_slow = 0; step("R4 break");
        cmp_slow = 1;
        for (int i = 0; i < SQ; i++) step("R2 full");
        chk("R2 slow trip", int'(trip_cause), 2);
        do_clear("R10 clear");
        chk("R10 cleared", int'(tripped), 0);

        // R3 fast path with a restart in the middle (R4)
        cmp_fast = 1;
        for (int i = 0; i < FQ - 1; i++) step("R3 short");
        cmp_fast = 0; step("R4 break");
        cmp_fast = 1;
        for (int i = 0; i < FQ - 1; i++) step("R4 rerun");
        chk("R4 no trip after restart", int'(tripped), 0);
        step("R3 full");
        chk("R3 fast trip", int'(trip_cause), 1);
        do_clear("R10 clear");

        // R5 disarmed path
        idle(); fast_arm = 0; cmp_fast = 1;
        for (int i = 0; i < FQ + 3; i++) step("R5 disarmed");
        chk("R5 disarmed no trip", int'(tripped), 0);
        fast_arm = 1;
        for (int i = 0; i < FQ - 1; i++) step("R5 armed run");
        chk("R5 count from arming", int'(tripped), 0);
        step("R5 armed full");
        chk("R5 trip after arm", int'(tripped), 1);
        // R10 trip wins when clear coincides with a persistent fault
        brk_clear = 1; step("R10 set wins");
        chk("R10 set wins", int'(tripped), 1);
        do_clear("R10 clear");

        // R6 direct sources, R9 ranking and first-cause retention
        idle(); ext_req = 1; pg_fail_req = 1; step("R6 ext+pg");
        chk("R9 rank ext over pg", int'(trip_cause), 4);
        idle(); ovp_req = 1; step("R9 later ovp");
        chk("R9 cause kept", int'(trip_cause), 4);
        do_clear("R10 clear");
        idle(); pg_fail_req = 1; step("R6 pg");
        chk("R6 pg cause", int'(trip_cause), 5);
        do_clear("R10 clear");

        // R11 sequencer reset restarts runs but keeps latch
        idle(); cmp_slow = 1;
        for (int i = 0; i < SQ - 1; i++) step("R11 run");
        seq_rst = 1; step("R11 restart");
        chk("R11 blocked", int'(tripped), 0);
        seq_rst = 0;
        for (int i = 0; i < SQ - 1; i++) step("R11 rerun");
        chk("R11 full run needed", int'(tripped), 0);
        step("R11 rerun end");
        idle(); seq_rst = 1; step("R11 keeps latch");
        chk("R11 latch kept", int'(tripped), 1);
        do_clear("R10 clear");

        // Random mix checked against the model
        for (int i = 0; i < 4000; i++) begin
            seq_rst     = ($urandom_range(0, 99) < 2);
            fast_arm    = ($urandom_range(0, 99) < 80);
            slow_arm    = ($urandom_range(0, 99) < 85);
            cmp_fast    = ($urandom_range(0, 99) < 70);
            cmp_slow    = ($urandom_range(0, 99) < 92);
            ovp_req     = ($urandom_range(0, 99) < 1);
            ext_req     = ($urandom_range(0, 99) < 1);
            pg_fail_req = ($urandom_range(0, 99) < 1);
            brk_clear   = ($urandom_range(0, 99) < 8);
            gate_req    = ($urandom_range(0, 99) < 90);
            step("R2 R3 R9 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule